// File: doc/BRIEF.md
# Power-State Phase-Shedding Controller

This block turns decoded power-state commands into per-channel control for two regulator domains: a core domain of up to four phases and a northbridge domain of up to two. Each command carries a valid strobe, one select flag per domain and two active-low power-state flags. Level 0 is the primary low-power flag and level 1 is the deeper one. For every domain that a command selects, the block stores the two flags. From the stored flags and the configured phase count, it works out which channels stay enabled and whether the single remaining channel runs in diode emulation or in continuous conduction.

The two flags are ranked, not treated as independent levels. The level-0 flag dominates. The level-1 flag on its own sheds nothing. Releasing level 0 brings back every configured channel in continuous conduction, even while level 1 stays asserted. The outputs are levels that a gate-drive stage downstream consumes directly.

Top module: `pss_phase_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both domains hold deasserted flags (high). Every configured channel is enabled and both diode-emulation outputs are 0.
- R2: The configured phase count n is clamped to the range 1 to the domain maximum. A value of 0 counts as 1. With level 0 deasserted, enable bits 0 to n-1 are 1 and all higher bits are 0. Bit i controls channel i+1. A change in configuration shows on the outputs in the same cycle.
- R3: Core domain with level 0 asserted (ps0_n = 0) and level 1 deasserted (ps1_n = 1): the enabled channels are min(n,2) and core_de = 0.
- R4: Core domain with both flags asserted (0): only channel bit 0 is enabled and core_de = 1.
- R5: Northbridge domain with level 0 asserted and level 1 deasserted: only channel bit 0 is enabled and nb_de = 1.
- R6: Northbridge domain with both flags asserted: the outputs are identical to the R5 state.
- R7: Whenever the stored level-0 flag is deasserted (1), the domain runs all n channels with its diode-emulation output at 0, whatever the level-1 flag is.
- R8: A command updates only the domains whose select flag is 1. A command with no select flag set leaves both domains' outputs unchanged.
- R9: The outputs for a command appear in the cycle after the one where cmd_vld is sampled high. They do not change in the strobe cycle itself, and they are held until the next selecting command.
- R10: Channel bit 0 is always enabled. The enables form a contiguous run from bit 0. A diode-emulation output is 1 only when exactly one channel of its domain is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| sel_core | input | 1 | Command applies to the core domain |
| sel_nb | input | 1 | Command applies to the northbridge domain |
| ps0_n | input | 1 | Level-0 power-state flag, active low |
| ps1_n | input | 1 | Level-1 power-state flag, active low |
| core_nph | input | 3 | Core configured phase count (clamped to 1..4) |
| nb_nph | input | 2 | Northbridge configured phase count (clamped to 1..2) |
| core_en | output | 4 | Core channel enables, bit i = channel i+1 |
| core_de | output | 1 | Core remaining channel in diode emulation |
| nb_en | output | 2 | Northbridge channel enables, bit i = channel i+1 |
| nb_de | output | 1 | Northbridge remaining channel in diode emulation |

## Verification
The hold properties assume that the phase-count configuration is quasi-static. A change of configuration is therefore excused from the no-change check in the cycle it happens. The stimulus changes configuration only in cycles without a command, and it checks that change on its own. The properties also take the flags and the select lines as meaningful only while cmd_vld is high. The bench drives them with random values at other times, so that a leak would show on the outputs.

// File: rtl/pss_pkg.sv
// Package: shared types and the flag-ranking function for the
// phase-shedding controller. Assumes active-low power-state flags.
package pss_pkg;

    // Stored flags of one domain; 1 means deasserted.
    typedef struct packed {
        logic ps0_n;
        logic ps1_n;
    } pss_flags_t;

    // Ranked power level after applying level-0 priority.
    typedef enum logic [1:0] {
        LVL_FULL = 2'd0,
        LVL_PS0  = 2'd1,
        LVL_PS1  = 2'd2
    } pss_level_t;

    localparam pss_flags_t PSS_FLAGS_RST = '{ps0_n: 1'b1, ps1_n: 1'b1};

    // Rank the flags: level 0 dominates, level 1 only deepens it.
    function automatic pss_level_t pss_rank(input pss_flags_t f);
        if (f.ps0_n)      return LVL_FULL;
        else if (f.ps1_n) return LVL_PS0;
        else              return LVL_PS1;
    endfunction

endpackage

// File: rtl/pss_flag_latch.sv
// Module: holds one domain's power-state flags between commands.
// Assumes load is a single-cycle qualified strobe; synchronous
// active-low reset returns both flags to deasserted.
module pss_flag_latch
    import pss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  pss_flags_t flags_in,
    output pss_flags_t flags_q,
    output pss_level_t level
);

    // Capture the command flags when this domain is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= PSS_FLAGS_RST;
        else if (load)
            flags_q <= flags_in;
    end

    // Rank the stored flags into a single power level.
    always_comb begin
        level = pss_rank(flags_q);
    end

endmodule

// File: rtl/pss_shed_map.sv
// Module: maps a ranked power level and a configured phase count to
// channel enables and a diode-emulation flag for one domain.
// Assumes KEEP_* values are at least 1; the configured count is
// clamped to 1..MAX_PH so channel 0 is never dropped.
module pss_shed_map
    import pss_pkg::*;
#(
    parameter int MAX_PH  = 4,
    parameter int CFG_W   = 3,
    parameter int KEEP_L0 = 2,
    parameter bit DE_L0   = 1'b0,
    parameter int KEEP_L1 = 1,
    parameter bit DE_L1   = 1'b1
) (
    input  logic [CFG_W-1:0]  cfg_ph,
    input  pss_level_t        level,
    output logic [MAX_PH-1:0] en,
    output logic              de
);

    localparam int KEEP0_C = (KEEP_L0 < 1) ? 1 : KEEP_L0;
    localparam int KEEP1_C = (KEEP_L1 < 1) ? 1 : KEEP_L1;

    int n_cfg;
    int n_act;

    // Clamp the configured phase count into the legal range.
    always_comb begin
        n_cfg = int'(cfg_ph);
        if (n_cfg < 1)
            n_cfg = 1;
        else if (n_cfg > MAX_PH)
            n_cfg = MAX_PH;
    end

    // Choose the active phase count and conduction mode per level.
    always_comb begin
        n_act = n_cfg;
        de    = 1'b0;
        unique case (level)
            LVL_PS0: begin
                n_act = (n_cfg < KEEP0_C) ? n_cfg : KEEP0_C;
                de    = DE_L0 && (n_act == 1);
            end
            LVL_PS1: begin
                n_act = (n_cfg < KEEP1_C) ? n_cfg : KEEP1_C;
                de    = DE_L1 && (n_act == 1);
            end
            default: begin
                n_act = n_cfg;
                de    = 1'b0;
            end
        endcase
    end

    // One enable per channel: on when below the active count.
    for (genvar g = 0; g < MAX_PH; g++) begin : g_ch
        assign en[g] = (g < n_act);
    end

endmodule

// File: rtl/pss_phase_ctrl.sv
// Module: top of the phase-shedding controller. Stores the flags per
// selected domain on each command and maps them to channel controls.
// Assumes cmd_vld marks a complete decoded command; configuration
// inputs are quasi-static.
module pss_phase_ctrl
    import pss_pkg::*;
#(
    parameter int CORE_MAX = 4,
    parameter int NB_MAX   = 2,
    localparam int CORE_CW = $clog2(CORE_MAX + 1) < 1 ? 1 : $clog2(CORE_MAX + 1),
    localparam int NB_CW   = $clog2(NB_MAX + 1) < 1 ? 1 : $clog2(NB_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_vld,
    input  logic                sel_core,
    input  logic                sel_nb,
    input  logic                ps0_n,
    input  logic                ps1_n,
    input  logic [CORE_CW-1:0]  core_nph,
    input  logic [NB_CW-1:0]    nb_nph,
    output logic [CORE_MAX-1:0] core_en,
    output logic                core_de,
    output logic [NB_MAX-1:0]   nb_en,
    output logic                nb_de
);

    pss_flags_t cmd_flags;
    pss_flags_t core_flags_q;
    pss_flags_t nb_flags_q;
    pss_level_t core_lvl;
    pss_level_t nb_lvl;
    logic       core_load;
    logic       nb_load;

    // Pack command flags and qualify per-domain loads.
    always_comb begin
        cmd_flags = '{ps0_n: ps0_n, ps1_n: ps1_n};
        core_load = cmd_vld && sel_core;
        nb_load   = cmd_vld && sel_nb;
    end

    pss_flag_latch i_core_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (core_load),
        .flags_in (cmd_flags),
        .flags_q  (core_flags_q),
        .level    (core_lvl)
    );

    pss_flag_latch i_nb_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (nb_load),
        .flags_in (cmd_flags),
        .flags_q  (nb_flags_q),
        .level    (nb_lvl)
    );

    // Core: level 0 keeps two phases in CCM, level 1 keeps one in DE.
    pss_shed_map #(
        .MAX_PH  (CORE_MAX),
        .CFG_W   (CORE_CW),
        .KEEP_L0 (2),
        .DE_L0   (1'b0),
        .KEEP_L1 (1),
        .DE_L1   (1'b1)
    ) i_core_map (
        .cfg_ph (core_nph),
        .level  (core_lvl),
        .en     (core_en),
        .de     (core_de)
    );

    // Northbridge: level 0 already keeps one phase in DE; level 1 adds nothing.
    pss_shed_map #(
        .MAX_PH  (NB_MAX),
        .CFG_W   (NB_CW),
        .KEEP_L0 (1),
        .DE_L0   (1'b1),
        .KEEP_L1 (1),
        .DE_L1   (1'b1)
    ) i_nb_map (
        .cfg_ph (nb_nph),
        .level  (nb_lvl),
        .en     (nb_en),
        .de     (nb_de)
    );

endmodule

// File: rtl/pss_phase_ctrl_chk.sv
// Module: assertion checker for pss_phase_ctrl, bound to every instance.
// Assumes configuration changes only in cycles without a command.
module pss_phase_ctrl_chk #(
    parameter int CORE_MAX = 4,
    parameter int NB_MAX   = 2,
    parameter int CORE_CW  = 3,
    parameter int NB_CW    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_vld,
    input logic                sel_core,
    input logic                sel_nb,
    input logic                ps0_n,
    input logic                ps1_n,
    input logic [CORE_CW-1:0]  core_nph,
    input logic [NB_CW-1:0]    nb_nph,
    input logic [CORE_MAX-1:0] core_en,
    input logic                core_de,
    input logic [NB_MAX-1:0]   nb_en,
    input logic                nb_de
);

    a_r10_core_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> core_en[0]);

    a_r10_nb_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> nb_en[0]);

    for (genvar g = 0; g < CORE_MAX - 1; g++) begin : g_thermo
        a_r10_core_contig: assert property (@(posedge clk) disable iff (!rst_n)
            !core_en[g] |-> !core_en[g+1]);
    end

    a_r10_core_de_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_de |-> ($countones(core_en) == 1));

    a_r10_nb_de_single: assert property (@(posedge clk) disable iff (!rst_n)
        nb_de |-> ($countones(nb_en) == 1));

    a_r7_core_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && sel_core && ps0_n) |=> !core_de);

    a_r7_nb_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && sel_nb && ps0_n) |=> !nb_de);

    a_r4_core_deep: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && sel_core && !ps0_n && !ps1_n) |=> (core_de && core_en == CORE_MAX'(1)));

    a_r5_nb_shed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && sel_nb && !ps0_n) |=> (nb_de && nb_en == NB_MAX'(1)));

    a_r8_core_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_vld && sel_core)) |=> (!$stable(core_nph) || ($stable(core_en) && $stable(core_de))));

    a_r8_nb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_vld && sel_nb)) |=> (!$stable(nb_nph) || ($stable(nb_en) && $stable(nb_de))));

endmodule

bind pss_phase_ctrl pss_phase_ctrl_chk #(
    .CORE_MAX (CORE_MAX),
    .NB_MAX   (NB_MAX),
    .CORE_CW  (CORE_CW),
    .NB_CW    (NB_CW)
) i_pss_phase_ctrl_chk (.*);

// File: tb/test_pss_phase_ctrl.sv
module test_pss_phase_ctrl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_vld;
    logic       sel_core;
    logic       sel_nb;
    logic       ps0_n;
    logic       ps1_n;
    logic [2:0] core_nph;
    logic [1:0] nb_nph;
    logic [3:0] core_en;
    logic       core_de;
    logic [1:0] nb_en;
    logic       nb_de;

    int n_chk  = 0;
    int n_fail = 0;
    bit mc0 = 1'b1, mc1 = 1'b1, mn0 = 1'b1, mn1 = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    pss_phase_ctrl i_pss_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .sel_core(sel_core),
        .sel_nb(sel_nb), .ps0_n(ps0_n), .ps1_n(ps1_n), .core_nph(core_nph),
        .nb_nph(nb_nph), .core_en(core_en), .core_de(core_de),
        .nb_en(nb_en), .nb_de(nb_de)
    );

    function automatic int clampn(int c, int mx);
        if (c < 1) return 1;
        if (c > mx) return mx;
        return c;
    endfunction

    function automatic logic [3:0] x_core_en(int c, bit p0, bit p1);
        int n = clampn(c, 4);
        if (!p0) n = p1 ? ((n < 2) ? n : 2) : 1;
        return 4'((1 << n) - 1);
    endfunction

    function automatic logic [1:0] x_nb_en(int c, bit p0);
        int n = clampn(c, 2);
        if (!p0) n = 1;
        return 2'((1 << n) - 1);
    endfunction

    task automatic check(string tag);
        logic [3:0] ec = x_core_en(int'(core_nph), mc0, mc1);
        logic       ecd = !mc0 && !mc1;
        logic [1:0] en = x_nb_en(int'(nb_nph), mn0);
        logic       end_ = !mn0;
        n_chk++;
        if (core_en !== ec || core_de !== ecd || nb_en !== en || nb_de !== end_) begin
            n_fail++;
            $display("FAIL %s: got core_en=%b core_de=%b nb_en=%b nb_de=%b exp %b %b %b %b",
                     tag, core_en, core_de, nb_en, nb_de, ec, ecd, en, end_);
        end
    endtask

    task automatic set_cfg(int c, int n, string tag);
        @(negedge clk);
        core_nph = 3'(c);
        nb_nph   = 2'(n);
        #1 check(tag);
    endtask

    task automatic cmd(bit sc, bit sn, bit p0, bit p1, string tag);
        @(negedge clk);
        cmd_vld = 1'b1; sel_core = sc; sel_nb = sn; ps0_n = p0; ps1_n = p1;
        #1 check("R9 strobe cycle");
        @(negedge clk);
        cmd_vld  = 1'b0;
        sel_core = 1'($urandom); sel_nb = 1'($urandom);
        ps0_n    = 1'($urandom); ps1_n  = 1'($urandom);
        if (sc) begin mc0 = p0; mc1 = p1; end
        if (sn) begin mn0 = p0; mn1 = p1; end
        check(tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; cmd_vld = 1'b0; sel_core = 1'b0; sel_nb = 1'b0;
        ps0_n = 1'b0; ps1_n = 1'b0; core_nph = 3'd4; nb_nph = 2'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");
        set_cfg(2, 1, "R2 config 2/1");
        set_cfg(0, 0, "R2 config zero clamps to 1");
        set_cfg(7, 3, "R2 config above max clamps");
        set_cfg(4, 2, "R2 config 4/2");
        cmd(1, 0, 0, 1, "R3 core level0 only");
        cmd(1, 0, 0, 0, "R4 core both levels");
        cmd(1, 0, 1, 0, "R7 core level0 released, level1 held");
        cmd(1, 0, 1, 0, "R7 core level1 alone sheds nothing");
        cmd(0, 1, 0, 1, "R5 nb level0 only");
        cmd(0, 1, 0, 0, "R6 nb both levels same as level0");
        cmd(0, 1, 1, 0, "R7 nb release");
        cmd(1, 1, 0, 0, "R8 both selected");
        cmd(0, 0, 1, 1, "R8 no select ignored");
        cmd(0, 1, 1, 1, "R8 nb only, core kept");
        set_cfg(1, 2, "R10 core single phase");
        cmd(1, 0, 0, 1, "R10 core 1 phase level0 keeps ch1 CCM");
        set_cfg(3, 2, "R3 core 3 phases");
        cmd(1, 0, 0, 1, "R3 core 3 phases level0 keeps 2");
        repeat (3) @(negedge clk);
        check("R9 held between commands");
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                set_cfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), "R2 random config");
            else
                cmd(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R8 random command");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule